// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is one DMA channel that works through a linked list of in-memory descriptors. Software places a chain of 32-byte descriptors in memory and pulses `start` with the address of the first one. The engine reads the eight descriptor words over a simple word-wide memory port and keeps the fields it needs. It then copies the programmed number of bytes from the source address to the destination address one word at a time. When that descriptor is finished, it follows the link word to the next descriptor, and it stops when the link is zero.

Each side of the copy has its own settings. One flag chooses whether the address advances or stays fixed. One flag chooses 32-bit or 128-bit accesses. One flag makes each access wait for a selected request line to be high. The engine reports completion through sticky end and interrupt flags. It reports an error code for a bad descriptor address or a bad length. A pause input halts it cleanly between word accesses, and it carries on when the pause input drops.

The memory port issues at most one read or one write per cycle and is always ready. Read data returns on `mem_rdata` in the cycle after `mem_rd`.

Top module: `dmac_chain_engine`

## Requirements
- R1: When idle, a `start` pulse clears the end, interrupt and error flags. The engine then reads eight words at `desc_addr` + 0, 4, ..., 28. Word 0 is control, word 1 is the source address, word 2 is the destination address, word 3 is the byte length and word 5 is the next-descriptor address. Word 4 and words 6 and 7 have no effect.
- R2: With both sides incrementing and 32-bit, the engine copies length/4 words in ascending order. The word at source+4k is written to destination+4k.
- R3: Control bit 8 (source) and bit 4 (destination) set increment. A value of 0 keeps that side's address fixed for every access.
- R4: Control bit 9 (source) and bit 5 (destination) select 128-bit access. Such an access is four word accesses at base+0, +4, +8 and +12. The base then moves by 16 when incrementing. A 32-bit access moves the base by 4.
- R5: A nonzero next-descriptor word makes the engine fetch that descriptor and continue. A zero word ends the chain and `busy` drops.
- R6: At the end of each descriptor `end_flag` is set. `irq_flag` is also set if control bit 0 of that descriptor is 1. Both flags stay set until the next start. A length of 0 completes at once with no data access.
- R7: Control bit 10 enables request pacing on the source side and bit 6 enables it on the destination side. Bits 20:16 select the `dreq` line. With pacing on, each access on that side waits until the selected line is high.
- R8: If the start address or a nonzero link has any of bits 4:0 set, `err_code` becomes 1 and the channel stops with `busy` low. No descriptor at that address is processed.
- R9: A length that is not a multiple of 4 sets `err_code` to 1 and stops the channel with no data write. If either side is 128-bit, the length must instead be a multiple of 16.
- R10: While `pause_req` is high, no memory access is issued. `paused` is high once the engine waits at an access point. After the pause drops, the transfer finishes with the same result as an unpaused run.
- R11: `mem_rd` and `mem_wr` are never high together, and no access happens while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a chain at `desc_addr` (ignored while busy) |
| desc_addr | input | AW | Byte address of the first descriptor |
| pause_req | input | 1 | Hold the engine at the next access point |
| dreq | input | REQ_LINES | Peripheral request lines used for pacing |
| mem_rd | output | 1 | Memory word read strobe |
| mem_wr | output | 1 | Memory word write strobe |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Chain in progress |
| paused | output | 1 | Stopped at an access point by `pause_req` |
| end_flag | output | 1 | A descriptor has completed since start |
| irq_flag | output | 1 | A completed descriptor requested an interrupt |
| err_code | output | 2 | 0 none, 1 bad descriptor address or length |

## Verification
The copy is tried with incrementing 32-bit sides, a two-descriptor chain that mixes a 128-bit destination with a fixed source, a fixed 128-bit source, and a fixed destination. Each mode leaves a different pattern in destination memory, so a wrong step size, a wrong group offset or an ignored increment flag shows up directly. Every write the engine issues is compared, in order, against a stream of expected writes that a behavioural walk of the chain produces. The walk also yields the expected end, interrupt and error flags. Further runs hold pacing lines low, hold a pause in the middle of a transfer, and use a zero length, a misaligned start address, a misaligned link and a bad length for a 128-bit side. Together these show that stalls cause no accesses and that error cases write nothing.

// File: rtl/dmac_pkg.sv
// Shared constants and types for the linked-descriptor DMA channel.
// Assumes a 32-bit word memory and descriptors of eight words.
package dmac_pkg;
    localparam int DESC_WORDS   = 8;
    localparam int W_CTRL       = 0;
    localparam int W_SRC        = 1;
    localparam int W_DST        = 2;
    localparam int W_LEN        = 3;
    localparam int W_LINK       = 5;

    localparam int CB_IRQ       = 0;
    localparam int CB_D_INC     = 4;
    localparam int CB_D_WIDE    = 5;
    localparam int CB_D_PACE    = 6;
    localparam int CB_S_INC     = 8;
    localparam int CB_S_WIDE    = 9;
    localparam int CB_S_PACE    = 10;
    localparam int CB_SEL_LO    = 16;

    localparam logic [1:0] ERR_NONE = 2'd0;
    localparam logic [1:0] ERR_CFG  = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREQ,
        ST_FCAP,
        ST_CHECK,
        ST_RREQ,
        ST_RCAP,
        ST_WREQ,
        ST_DONE
    } dmac_state_t;
endpackage

// File: rtl/dmac_side.sv
// Address generator for one side (source or destination) of a copy.
// Assumes the base is loaded before the first step; a 128-bit access is
// four word steps, and the base moves only after the fourth.
module dmac_side #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base_in,
    input  logic          inc,
    input  logic          wide,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          grp_first
);
    localparam logic [AW-1:0] STEP_NARROW = AW'(4);
    localparam logic [AW-1:0] STEP_WIDE   = AW'(16);

    logic [AW-1:0] base_q;
    logic [1:0]    off_q;

    // Hold the access base and the word offset inside a 128-bit group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            off_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            off_q  <= '0;
        end else if (step) begin
            if (wide) begin
                off_q <= off_q + 2'd1;
                if (off_q == 2'd3 && inc)
                    base_q <= base_q + STEP_WIDE;
            end else if (inc) begin
                base_q <= base_q + STEP_NARROW;
            end
        end
    end

    // Word address of the current access and start-of-access marker.
    always_comb begin
        addr      = base_q + AW'({off_q, 2'b00});
        grp_first = wide ? (off_q == 2'd0) : 1'b1;
    end
endmodule

// File: rtl/dmac_seq.sv
// Channel sequencer: descriptor fetch, field latch, length check,
// word copy loop, completion flags and link following.
// Assumes read data arrives one cycle after a read strobe and that the
// memory accepts every access in the cycle it is issued.
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int AW        = 16,
    parameter int REQ_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        desc_addr,
    input  logic                 pause_req,
    input  logic [REQ_LINES-1:0] dreq,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [AW-1:0]        mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          mem_rdata,
    output logic                 busy,
    output logic                 paused,
    output logic                 end_flag,
    output logic                 irq_flag,
    output logic [1:0]           err_code,
    output logic                 side_load,
    output logic [AW-1:0]        s_base,
    output logic [AW-1:0]        d_base,
    output logic                 s_inc,
    output logic                 s_wide,
    output logic                 d_inc,
    output logic                 d_wide,
    output logic                 s_step,
    output logic                 d_step,
    input  logic [AW-1:0]        s_addr,
    input  logic [AW-1:0]        d_addr,
    input  logic                 s_first,
    input  logic                 d_first
);
    localparam int SELW = $clog2(REQ_LINES);
    localparam int IDXW = $clog2(DESC_WORDS);

    dmac_state_t     st_q;
    logic [AW-1:0]   fptr_q;
    logic [IDXW-1:0] widx_q;
    logic [31:0]     len_q;
    logic [31:0]     remain_q;
    logic [31:0]     dbuf_q;
    logic [AW-1:0]   link_q;
    logic            link_zero_q;
    logic            irq_en_q;
    logic            s_pace_q;
    logic            d_pace_q;
    logic [SELW-1:0] sel_q;
    logic            end_q;
    logic            irq_q;
    logic [1:0]      err_q;
    logic            len_bad;
    logic            s_go;
    logic            d_go;

    // Length legality and pacing/pause gates for the two access points.
    always_comb begin
        len_bad = (s_wide | d_wide) ? (len_q[3:0] != 4'd0) : (len_q[1:0] != 2'd0);
        s_go    = !pause_req && (!s_pace_q || !s_first || dreq[sel_q]);
        d_go    = !pause_req && (!d_pace_q || !d_first || dreq[sel_q]);
    end

    // Memory port drive and side step strobes for the current state.
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = fptr_q + AW'({widx_q, 2'b00});
        mem_wdata = dbuf_q;
        s_step    = 1'b0;
        d_step    = 1'b0;
        case (st_q)
            ST_FREQ: mem_rd = !pause_req;
            ST_RREQ: begin
                mem_addr = s_addr;
                mem_rd   = s_go;
                s_step   = s_go;
            end
            ST_WREQ: begin
                mem_addr = d_addr;
                mem_wr   = d_go;
                d_step   = d_go;
            end
            default: ;
        endcase
    end

    // Sequencer state, descriptor fields and completion/error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            fptr_q      <= '0;
            widx_q      <= '0;
            len_q       <= '0;
            remain_q    <= '0;
            dbuf_q      <= '0;
            link_q      <= '0;
            link_zero_q <= 1'b1;
            irq_en_q    <= 1'b0;
            s_inc       <= 1'b0;
            s_wide      <= 1'b0;
            s_pace_q    <= 1'b0;
            d_inc       <= 1'b0;
            d_wide      <= 1'b0;
            d_pace_q    <= 1'b0;
            sel_q       <= '0;
            s_base      <= '0;
            d_base      <= '0;
            end_q       <= 1'b0;
            irq_q       <= 1'b0;
            err_q       <= ERR_NONE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        end_q <= 1'b0;
                        irq_q <= 1'b0;
                        if (desc_addr[4:0] != 5'd0) begin
                            err_q <= ERR_CFG;
                        end else begin
                            err_q  <= ERR_NONE;
                            fptr_q <= desc_addr;
                            widx_q <= '0;
                            st_q   <= ST_FREQ;
                        end
                    end
                end
                ST_FREQ: begin
                    if (!pause_req)
                        st_q <= ST_FCAP;
                end
                ST_FCAP: begin
                    case (int'(widx_q))
                        W_CTRL: begin
                            irq_en_q <= mem_rdata[CB_IRQ];
                            d_inc    <= mem_rdata[CB_D_INC];
                            d_wide   <= mem_rdata[CB_D_WIDE];
                            d_pace_q <= mem_rdata[CB_D_PACE];
                            s_inc    <= mem_rdata[CB_S_INC];
                            s_wide   <= mem_rdata[CB_S_WIDE];
                            s_pace_q <= mem_rdata[CB_S_PACE];
                            sel_q    <= mem_rdata[CB_SEL_LO +: SELW];
                        end
                        W_SRC:  s_base <= mem_rdata[AW-1:0];
                        W_DST:  d_base <= mem_rdata[AW-1:0];
                        W_LEN:  len_q  <= mem_rdata;
                        W_LINK: begin
                            link_q      <= mem_rdata[AW-1:0];
                            link_zero_q <= (mem_rdata == 32'd0);
                        end
                        default: ;
                    endcase
                    if (int'(widx_q) == DESC_WORDS - 1) begin
                        st_q <= ST_CHECK;
                    end else begin
                        widx_q <= widx_q + 1'b1;
                        st_q   <= ST_FREQ;
                    end
                end
                ST_CHECK: begin
                    if (len_bad) begin
                        err_q <= ERR_CFG;
                        st_q  <= ST_IDLE;
                    end else begin
                        remain_q <= len_q;
                        st_q     <= (len_q == 32'd0) ? ST_DONE : ST_RREQ;
                    end
                end
                ST_RREQ: begin
                    if (s_go)
                        st_q <= ST_RCAP;
                end
                ST_RCAP: begin
                    dbuf_q <= mem_rdata;
                    st_q   <= ST_WREQ;
                end
                ST_WREQ: begin
                    if (d_go) begin
                        remain_q <= remain_q - 32'd4;
                        st_q     <= (remain_q == 32'd4) ? ST_DONE : ST_RREQ;
                    end
                end
                ST_DONE: begin
                    end_q <= 1'b1;
                    if (irq_en_q)
                        irq_q <= 1'b1;
                    if (link_zero_q) begin
                        st_q <= ST_IDLE;
                    end else if (link_q[4:0] != 5'd0) begin
                        err_q <= ERR_CFG;
                        st_q  <= ST_IDLE;
                    end else begin
                        fptr_q <= link_q;
                        widx_q <= '0;
                        st_q   <= ST_FREQ;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Status outputs and the one-cycle side load after a legal fetch.
    always_comb begin
        busy      = (st_q != ST_IDLE);
        paused    = pause_req && (st_q == ST_FREQ || st_q == ST_RREQ || st_q == ST_WREQ);
        end_flag  = end_q;
        irq_flag  = irq_q;
        err_code  = err_q;
        side_load = (st_q == ST_CHECK) && !len_bad;
    end
endmodule

// File: rtl/dmac_chain_engine.sv
// Top of the linked-descriptor DMA channel. Joins the sequencer with one
// address generator per side. Assumes an always-ready word memory with
// read data one cycle after the read strobe.
module dmac_chain_engine #(
    parameter int AW        = 16,
    parameter int REQ_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        desc_addr,
    input  logic                 pause_req,
    input  logic [REQ_LINES-1:0] dreq,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [AW-1:0]        mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          mem_rdata,
    output logic                 busy,
    output logic                 paused,
    output logic                 end_flag,
    output logic                 irq_flag,
    output logic [1:0]           err_code
);
    localparam int NSIDE = 2;

    logic            side_load;
    logic [AW-1:0]   base_v [NSIDE];
    logic            inc_v  [NSIDE];
    logic            wide_v [NSIDE];
    logic            step_v [NSIDE];
    logic [AW-1:0]   addr_v [NSIDE];
    logic            first_v[NSIDE];

    dmac_seq #(
        .AW        (AW),
        .REQ_LINES (REQ_LINES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .desc_addr (desc_addr),
        .pause_req (pause_req),
        .dreq      (dreq),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .paused    (paused),
        .end_flag  (end_flag),
        .irq_flag  (irq_flag),
        .err_code  (err_code),
        .side_load (side_load),
        .s_base    (base_v[0]),
        .d_base    (base_v[1]),
        .s_inc     (inc_v[0]),
        .s_wide    (wide_v[0]),
        .d_inc     (inc_v[1]),
        .d_wide    (wide_v[1]),
        .s_step    (step_v[0]),
        .d_step    (step_v[1]),
        .s_addr    (addr_v[0]),
        .d_addr    (addr_v[1]),
        .s_first   (first_v[0]),
        .d_first   (first_v[1])
    );

    // One address generator per side: index 0 source, index 1 destination.
    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dmac_side #(.AW(AW)) u_side (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (side_load),
            .base_in   (base_v[g]),
            .inc       (inc_v[g]),
            .wide      (wide_v[g]),
            .step      (step_v[g]),
            .addr      (addr_v[g]),
            .grp_first (first_v[g])
        );
    end
endmodule

// File: rtl/dmac_chain_engine_chk.sv
// Port-level protocol checks for the DMA channel, bound to the top.
module dmac_chain_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       pause_req,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       busy,
    input logic       irq_flag,
    input logic       end_flag,
    input logic [1:0] err_code
);
    // R11: one access per cycle at most.
    assert_single_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R11: an idle channel issues no access.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_wr));

    // R10: a pause request blocks every access.
    assert_pause_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> !(mem_rd || mem_wr));

    // R8: an error leaves the channel stopped.
    assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0) |-> !busy);

    // R1: the channel becomes busy only after a start pulse.
    assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R6: the interrupt flag never rises without the end flag.
    assert_irq_with_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> end_flag);
endmodule

bind dmac_chain_engine dmac_chain_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pause_req (pause_req),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .busy      (busy),
    .irq_flag  (irq_flag),
    .end_flag  (end_flag),
    .err_code  (err_code)
);

// File: tb/dmac_chain_engine_bench.sv
module dmac_chain_engine_bench;
    localparam int AW = 16;
    localparam int NW = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [AW-1:0] desc_addr = '0;
    logic        pause_req = 1'b0;
    logic [31:0] dreq = '0;
    logic        mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        busy, paused, end_flag, irq_flag;
    logic [1:0]  err_code;

    logic [31:0] mem     [0:NW-1];
    logic [31:0] exp_mem [0:NW-1];
    logic [31:0] wq_a[$];
    logic [31:0] wq_d[$];
    int total = 0;
    int bad = 0;
    int wcount = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dmac_chain_engine #(.AW(AW), .REQ_LINES(32)) u_dmac_chain_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_addr(desc_addr),
        .pause_req(pause_req), .dreq(dreq), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .paused(paused), .end_flag(end_flag), .irq_flag(irq_flag),
        .err_code(err_code)
    );

    // Word memory: write at the edge, read data one cycle after the strobe.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the write stream against the reference.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd && mem_wr) chk("R11 dual access", 1, 0);
            if (pause_req && (mem_rd || mem_wr)) chk("R10 access during pause", 1, 0);
            if (mem_wr) begin
                wcount++;
                if (wq_a.size() == 0) begin
                    chk("R2 unexpected write addr", 32'(mem_addr), 32'hFFFFFFFF);
                end else begin
                    chk("R2 write addr", 32'(mem_addr), wq_a.pop_front());
                    chk("R2 write data", mem_wdata, wq_d.pop_front());
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr_word(input int a, input logic [31:0] v);
        mem[a/4] = v;
        exp_mem[a/4] = v;
    endtask

    task automatic put_desc(input int a, input logic [31:0] ctrl, input logic [31:0] s,
                            input logic [31:0] d, input logic [31:0] n, input logic [31:0] nx);
        wr_word(a, ctrl);      wr_word(a + 4, s);   wr_word(a + 8, d);
        wr_word(a + 12, n);    wr_word(a + 16, 32'h5A5A0000);
        wr_word(a + 20, nx);   wr_word(a + 24, 32'hDEAD0001); wr_word(a + 28, 32'hDEAD0002);
    endtask

    task automatic clear_dst();
        for (int k = 512; k < 768; k++) begin
            mem[k] = 32'd0; exp_mem[k] = 32'd0;
        end
    endtask

    // Behavioural walk of the chain on the expected memory image.
    task automatic run_model(input int da, output int e, output bit en, output bit iq);
        int cur;
        logic [31:0] ctrl, s, d, n, nx, v;
        int unit, sa, dd;
        cur = da; e = 0; en = 0; iq = 0;
        while (1) begin
            if (cur % 32 != 0) begin e = 1; return; end
            ctrl = exp_mem[cur/4]; s = exp_mem[cur/4+1]; d = exp_mem[cur/4+2];
            n = exp_mem[cur/4+3]; nx = exp_mem[cur/4+5];
            unit = (ctrl[9] || ctrl[5]) ? 16 : 4;
            if (int'(n) % unit != 0) begin e = 1; return; end
            for (int w = 0; w < int'(n) / 4; w++) begin
                if (ctrl[9]) sa = int'(s) + (ctrl[8] ? 16 * (w / 4) : 0) + 4 * (w % 4);
                else         sa = int'(s) + (ctrl[8] ? 4 * w : 0);
                if (ctrl[5]) dd = int'(d) + (ctrl[4] ? 16 * (w / 4) : 0) + 4 * (w % 4);
                else         dd = int'(d) + (ctrl[4] ? 4 * w : 0);
                v = exp_mem[sa/4];
                exp_mem[dd/4] = v;
                wq_a.push_back(32'(dd));
                wq_d.push_back(v);
            end
            en = 1;
            if (ctrl[0]) iq = 1;
            if (nx == 0) return;
            cur = int'(nx);
        end
    endtask

    task automatic pulse_start(input int a);
        @(negedge clk);
        desc_addr = AW'(a);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic cmp_mem(input string req);
        int mism = 0;
        for (int k = 0; k < NW; k++)
            if (mem[k] !== exp_mem[k]) mism++;
        chk(req, mism, 0);
        chk({req, " write queue drained"}, wq_a.size(), 0);
    endtask

    task automatic run_case(input string req, input int a);
        int e; bit en, iq;
        run_model(a, e, en, iq);
        pulse_start(a);
        @(negedge clk);
        wait_idle();
        @(negedge clk);
        cmp_mem({req, " memory"});
        chk({req, " end_flag"}, end_flag, en);
        chk({req, " irq_flag"}, irq_flag, iq);
        chk({req, " err_code"}, err_code, e);
    endtask

    initial begin
        for (int k = 0; k < NW; k++) begin
            mem[k] = 32'd0; exp_mem[k] = 32'd0;
        end
        for (int k = 256; k < 512; k++)
            wr_word(4 * k, (32'(k) * 32'h01010101) ^ 32'hA5000000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R1, R6, R8).
        chk("R1 reset busy", busy, 0);
        chk("R6 reset end_flag", end_flag, 0);
        chk("R6 reset irq_flag", irq_flag, 0);
        chk("R8 reset err_code", err_code, 0);

        // R2, R1: plain incrementing 32-bit copy with interrupt enabled.
        clear_dst();
        put_desc(32'h000, 32'h00000111, 32'h400, 32'h800, 32, 0);
        run_case("R2 linear copy", 32'h000);

        // R5, R4, R3: two-descriptor chain, 128-bit dest then fixed source.
        clear_dst();
        put_desc(32'h020, 32'h00000130, 32'h400, 32'h800, 32, 32'h040);
        put_desc(32'h040, 32'h00000010, 32'h440, 32'h880, 16, 0);
        run_case("R5 chain", 32'h020);

        // R4: fixed 128-bit source repeats the same four words.
        clear_dst();
        put_desc(32'h000, 32'h00000211, 32'h480, 32'h800, 48, 0);
        run_case("R4 fixed wide source", 32'h000);

        // R3: fixed 32-bit destination keeps only the last word.
        clear_dst();
        put_desc(32'h000, 32'h00000100, 32'h400, 32'h900, 20, 0);
        run_case("R3 fixed destination", 32'h000);
        chk("R3 fixed destination word", mem[32'h900/4], mem[32'h410/4]);

        // R6: zero length completes at once with no access.
        clear_dst();
        put_desc(32'h000, 32'h00000111, 32'h400, 32'h800, 0, 0);
        run_case("R6 zero length", 32'h000);

        // R8: misaligned start address.
        clear_dst();
        run_case("R8 misaligned start", 32'h010);

        // R9: length not a multiple of 16 with a 128-bit side.
        clear_dst();
        put_desc(32'h000, 32'h00000120, 32'h400, 32'h800, 24, 0);
        run_case("R9 bad length", 32'h000);

        // R8: first descriptor completes, misaligned link then errors.
        clear_dst();
        put_desc(32'h060, 32'h00000111, 32'h400, 32'h800, 8, 32'h0A4);
        run_case("R8 misaligned link", 32'h060);

        // R7: pacing on both sides with request line 3 held low.
        begin
            int e; bit en, iq;
            clear_dst();
            put_desc(32'h000, 32'h00030550, 32'h400, 32'h800, 32, 0);
            run_model(32'h000, e, en, iq);
            wcount = 0;
            dreq = 32'h00000004;
            pulse_start(32'h000);
            repeat (60) @(negedge clk);
            chk("R7 stalled writes", wcount, 0);
            chk("R7 stalled busy", busy, 1);
            dreq = 32'h00000008;
            wait_idle();
            @(negedge clk);
            cmp_mem("R7 paced memory");
            chk("R7 paced end_flag", end_flag, en);
            dreq = '0;
        end

        // R10: pause in the middle of a transfer, then resume.
        begin
            int e; bit en, iq; int snap;
            clear_dst();
            put_desc(32'h000, 32'h00000111, 32'h400, 32'h800, 64, 0);
            run_model(32'h000, e, en, iq);
            pulse_start(32'h000);
            repeat (30) @(negedge clk);
            pause_req = 1'b1;
            repeat (3) @(negedge clk);
            snap = wcount;
            repeat (40) @(negedge clk);
            chk("R10 no writes while paused", wcount, snap);
            chk("R10 paused output", paused, 1);
            pause_req = 1'b0;
            wait_idle();
            @(negedge clk);
            cmp_mem("R10 resumed memory");
            chk("R10 resumed irq_flag", irq_flag, iq);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule